// File: doc/BRIEF.md
# Pending Miss Target Queue

This block holds the requests that wait on one outstanding cache miss, strictly in arrival order. Each stored target has a command code, an order tag, a ready time, a source type and a pending-mark bit. The caller pushes targets at the tail, retires them from the head, and reads the head entry's order tag and ready time when the list is promoted to active service. The pending-mark bit is stored and returned as written and has no effect inside the block.

Two summary flags travel with the queue. The exclusive flag records that some non-snoop target needs a writable copy. The upgrade flag records that some non-snoop target assumes a read-only copy is already held. When that copy is lost, one rewrite request turns every stored upgrade-type command into the command that still works without the copy. The rewrite covers all entries in one cycle. A second queue of the same shape can be appended in one cycle. Its flags are merged in with the entries.

Top module: `pending_target_queue`

## Requirements
- R1: During and after reset the queue is empty, `count` is 0, `head_valid` is low and both summary flags are low.
- R2: Targets leave in the order they entered. The head shows the oldest entry's command, order tag, ready time, source and mark bit unchanged.
- R3: An accepted push whose source is not snoop (source codes: 0 CPU, 1 snoop, 2 prefetcher) sets `flag_excl` when its command needs an exclusive copy. Command codes: 0 read, 1 read-exclusive, 2 upgrade, 3 store-conditional upgrade, 4 store-conditional, 5 write, 6 store-conditional-upgrade-fail, 7 store-conditional-fail, 8 prefetch. Codes 1 to 7 need an exclusive copy. Only an accepted flag clear lowers `flag_excl`.
- R4: An accepted push whose source is not snoop sets `flag_upg` when its command is 2, 3 or 4.
- R5: A push from a snoop source never changes either summary flag.
- R6: A `rewrite` while `flag_upg` is high changes, by the next cycle, every stored entry as follows: code 2 becomes 1, code 3 becomes 6 and code 4 becomes 7. Other codes stay the same. The same edge clears `flag_upg`, unless an entry pushed in that cycle sets it again. An entry pushed in the same cycle is stored without being rewritten.
- R7: A `rewrite` while `flag_upg` is low leaves every stored command unchanged, including upgrade codes that came from snoops.
- R8: In one cycle, push and pop may both fire. The pop removes the head and the push still goes in, even when the queue is full. A push to a full queue without a pop is dropped. A pop of an empty queue is ignored. `count` never exceeds DEPTH, and `full` and `empty` follow `count`.
- R9: `flag_clear` lowers both flags only when the queue is empty and no push or append is requested in that cycle. At any other time it is ignored.
- R10: An append adds `app_cnt` entries from the flattened `app_*` buses (entry k in slice k) behind the existing entries, in index order, and ORs `app_excl` and `app_upg` into the flags. It is taken only when no push and no pop are requested in that cycle and the result fits in DEPTH. Otherwise nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push one target at the tail |
| push_cmd | input | 4 | Command code of pushed target |
| push_order | input | ORDER_W | Order tag of pushed target |
| push_time | input | TIME_W | Ready time of pushed target |
| push_src | input | 2 | Source of pushed target |
| push_mark | input | 1 | Pending-mark bit of pushed target |
| pop | input | 1 | Retire the head entry |
| rewrite | input | 1 | Bulk upgrade rewrite request |
| flag_clear | input | 1 | Clear both summary flags |
| app_valid | input | 1 | Append another queue's contents |
| app_cnt | input | CNT_W | Number of entries to append |
| app_cmd | input | 4*DEPTH | Appended commands |
| app_order | input | ORDER_W*DEPTH | Appended order tags |
| app_time | input | TIME_W*DEPTH | Appended ready times |
| app_src | input | 2*DEPTH | Appended sources |
| app_mark | input | DEPTH | Appended mark bits |
| app_excl | input | 1 | Other queue's exclusive flag |
| app_upg | input | 1 | Other queue's upgrade flag |
| count | output | CNT_W | Stored entries |
| empty | output | 1 | No entries |
| full | output | 1 | DEPTH entries |
| head_valid | output | 1 | Head fields are meaningful |
| head_cmd | output | 4 | Head command |
| head_order | output | ORDER_W | Head order tag |
| head_time | output | TIME_W | Head ready time |
| head_src | output | 2 | Head source |
| head_mark | output | 1 | Head mark bit |
| flag_excl | output | 1 | Exclusive summary flag |
| flag_upg | output | 1 | Upgrade summary flag |

## Verification
The assertions assume two things about the inputs. First, `app_cnt` never exceeds DEPTH. Second, when the head is stable, it is changed only by a pop or a rewrite, because an append or push only lands behind existing entries. The random stimulus keeps `app_cnt` between 0 and DEPTH and raises push, pop, rewrite, clear and append in any mix, including the combinations the block must reject. Directed sequences drive the full queue, the empty queue, snoop-sourced upgrades and rewrites that must do nothing.

// File: rtl/ptq_pkg.sv
package ptq_pkg;

  localparam logic [3:0] CMD_READ        = 4'd0;
  localparam logic [3:0] CMD_READ_EX     = 4'd1;
  localparam logic [3:0] CMD_UPGRADE     = 4'd2;
  localparam logic [3:0] CMD_SC_UPGRADE  = 4'd3;
  localparam logic [3:0] CMD_STORE_COND  = 4'd4;
  localparam logic [3:0] CMD_WRITE       = 4'd5;
  localparam logic [3:0] CMD_SC_UPG_FAIL = 4'd6;
  localparam logic [3:0] CMD_SC_FAIL     = 4'd7;
  localparam logic [3:0] CMD_PREFETCH    = 4'd8;

  localparam logic [1:0] SRC_CPU   = 2'd0;
  localparam logic [1:0] SRC_SNOOP = 2'd1;
  localparam logic [1:0] SRC_PREF  = 2'd2;

  function automatic logic needs_exclusive(input logic [3:0] cmd);
    return (cmd >= CMD_READ_EX) && (cmd <= CMD_SC_FAIL);
  endfunction

  function automatic logic is_upgrade_kind(input logic [3:0] cmd);
    return (cmd == CMD_UPGRADE) || (cmd == CMD_SC_UPGRADE) ||
           (cmd == CMD_STORE_COND);
  endfunction

  function automatic logic [3:0] upgrade_replacement(input logic [3:0] cmd);
    case (cmd)
      CMD_UPGRADE:    return CMD_READ_EX;
      CMD_SC_UPGRADE: return CMD_SC_UPG_FAIL;
      CMD_STORE_COND: return CMD_SC_FAIL;
      default:        return cmd;
    endcase
  endfunction

endpackage

// File: rtl/ptq_flag_unit.sv
module ptq_flag_unit
  import ptq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rewrite_fire,
  input  logic       clear_fire,
  input  logic       push_fire,
  input  logic [3:0] push_cmd,
  input  logic [1:0] push_src,
  input  logic       merge_fire,
  input  logic       merge_excl,
  input  logic       merge_upg,
  output logic       flag_excl,
  output logic       flag_upg
);

  logic push_counts;
  logic set_excl;
  logic set_upg;
  logic excl_next;
  logic upg_next;

  assign push_counts = push_fire && (push_src != SRC_SNOOP);
  assign set_excl = (push_counts && needs_exclusive(push_cmd)) ||
                    (merge_fire && merge_excl);
  assign set_upg  = (push_counts && is_upgrade_kind(push_cmd)) ||
                    (merge_fire && merge_upg);

  always_comb begin
    excl_next = flag_excl;
    upg_next  = flag_upg;
    if (rewrite_fire) upg_next = 1'b0;
    if (clear_fire) begin
      excl_next = 1'b0;
      upg_next  = 1'b0;
    end
    excl_next = excl_next | set_excl;
    upg_next  = upg_next | set_upg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_excl <= 1'b0;
      flag_upg  <= 1'b0;
    end else begin
      flag_excl <= excl_next;
      flag_upg  <= upg_next;
    end
  end

endmodule

// File: rtl/ptq_ptr_ctrl.sv
module ptq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_fire,
  input  logic             pop_fire,
  input  logic             merge_fire,
  input  logic [CNT_W-1:0] merge_cnt,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] add_amt;
  logic [CNT_W-1:0] sub_amt;

  assign add_amt = push_fire  ? CNT_W'(1) :
                   merge_fire ? merge_cnt : '0;
  assign sub_amt = pop_fire ? CNT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + PTR_W'(sub_amt);
      wr_ptr <= wr_ptr + add_amt[PTR_W-1:0];
      count  <= count + add_amt - sub_amt;
    end
  end

endmodule

// File: rtl/ptq_slot_array.sv
module ptq_slot_array
  import ptq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ORDER_W = 8,
  parameter int TIME_W  = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PTR_W-1:0]           rd_ptr,
  input  logic [PTR_W-1:0]           wr_ptr,
  input  logic [CNT_W-1:0]           count,
  input  logic                       push_fire,
  input  logic [3:0]                 push_cmd,
  input  logic [ORDER_W-1:0]         push_order,
  input  logic [TIME_W-1:0]          push_time,
  input  logic [1:0]                 push_src,
  input  logic                       push_mark,
  input  logic                       merge_fire,
  input  logic [CNT_W-1:0]           merge_cnt,
  input  logic [4*DEPTH-1:0]         merge_cmd,
  input  logic [ORDER_W*DEPTH-1:0]   merge_order,
  input  logic [TIME_W*DEPTH-1:0]    merge_time,
  input  logic [2*DEPTH-1:0]         merge_src,
  input  logic [DEPTH-1:0]           merge_mark,
  input  logic                       rewrite_fire,
  output logic [3:0]                 head_cmd,
  output logic [ORDER_W-1:0]         head_order,
  output logic [TIME_W-1:0]          head_time,
  output logic [1:0]                 head_src,
  output logic                       head_mark
);

  logic [3:0]         cmd_q   [DEPTH];
  logic [ORDER_W-1:0] order_q [DEPTH];
  logic [TIME_W-1:0]  time_q  [DEPTH];
  logic [1:0]         src_q   [DEPTH];
  logic [DEPTH-1:0]   mark_q;

  logic [DEPTH-1:0]   sel_push;
  logic [DEPTH-1:0]   sel_merge;
  logic [DEPTH-1:0]   sel_rewrite;
  logic [PTR_W-1:0]   merge_idx [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [PTR_W-1:0] from_tail;
    logic [PTR_W-1:0] from_head;
    assign from_tail      = PTR_W'(s) - wr_ptr;
    assign from_head      = PTR_W'(s) - rd_ptr;
    assign merge_idx[s]   = from_tail;
    assign sel_push[s]    = push_fire && (from_tail == '0);
    assign sel_merge[s]   = merge_fire && ({1'b0, from_tail} < merge_cnt);
    assign sel_rewrite[s] = rewrite_fire && ({1'b0, from_head} < count);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        cmd_q[s]   <= '0;
        order_q[s] <= '0;
        time_q[s]  <= '0;
        src_q[s]   <= '0;
      end
      mark_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (sel_push[s]) begin
          cmd_q[s]   <= push_cmd;
          order_q[s] <= push_order;
          time_q[s]  <= push_time;
          src_q[s]   <= push_src;
          mark_q[s]  <= push_mark;
        end else if (sel_merge[s]) begin
          cmd_q[s]   <= merge_cmd[4*merge_idx[s] +: 4];
          order_q[s] <= merge_order[ORDER_W*merge_idx[s] +: ORDER_W];
          time_q[s]  <= merge_time[TIME_W*merge_idx[s] +: TIME_W];
          src_q[s]   <= merge_src[2*merge_idx[s] +: 2];
          mark_q[s]  <= merge_mark[merge_idx[s]];
        end else if (sel_rewrite[s]) begin
          cmd_q[s]   <= upgrade_replacement(cmd_q[s]);
        end
      end
    end
  end

  assign head_cmd   = cmd_q[rd_ptr];
  assign head_order = order_q[rd_ptr];
  assign head_time  = time_q[rd_ptr];
  assign head_src   = src_q[rd_ptr];
  assign head_mark  = mark_q[rd_ptr];

endmodule

// File: rtl/pending_target_queue.sv
module pending_target_queue #(
  parameter int DEPTH   = 8,
  parameter int ORDER_W = 8,
  parameter int TIME_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_valid,
  input  logic [3:0]                  push_cmd,
  input  logic [ORDER_W-1:0]          push_order,
  input  logic [TIME_W-1:0]           push_time,
  input  logic [1:0]                  push_src,
  input  logic                        push_mark,
  input  logic                        pop,
  input  logic                        rewrite,
  input  logic                        flag_clear,
  input  logic                        app_valid,
  input  logic [$clog2(DEPTH):0]      app_cnt,
  input  logic [4*DEPTH-1:0]          app_cmd,
  input  logic [ORDER_W*DEPTH-1:0]    app_order,
  input  logic [TIME_W*DEPTH-1:0]     app_time,
  input  logic [2*DEPTH-1:0]          app_src,
  input  logic [DEPTH-1:0]            app_mark,
  input  logic                        app_excl,
  input  logic                        app_upg,
  output logic [$clog2(DEPTH):0]      count,
  output logic                        empty,
  output logic                        full,
  output logic                        head_valid,
  output logic [3:0]                  head_cmd,
  output logic [ORDER_W-1:0]          head_order,
  output logic [TIME_W-1:0]           head_time,
  output logic [1:0]                  head_src,
  output logic                        head_mark,
  output logic                        flag_excl,
  output logic                        flag_upg
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W:0]   merged_total;

  // named internal events, observed by the checker
  logic push_acc;
  logic pop_acc;
  logic app_acc;
  logic clear_acc;
  logic rewrite_acc;

  assign empty        = (count == '0);
  assign full         = (count == CNT_W'(DEPTH));
  assign head_valid   = !empty;
  assign merged_total = {1'b0, count} + {1'b0, app_cnt};

  assign pop_acc     = pop && !empty;
  assign push_acc    = push_valid && (!full || pop);
  assign app_acc     = app_valid && !push_valid && !pop &&
                       (merged_total <= (CNT_W+1)'(DEPTH));
  assign clear_acc   = flag_clear && empty && !push_valid && !app_valid;
  assign rewrite_acc = rewrite && flag_upg;

  ptq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_fire  (push_acc),
    .pop_fire   (pop_acc),
    .merge_fire (app_acc),
    .merge_cnt  (app_cnt),
    .rd_ptr     (rd_ptr),
    .wr_ptr     (wr_ptr),
    .count      (count)
  );

  ptq_slot_array #(.DEPTH(DEPTH), .ORDER_W(ORDER_W), .TIME_W(TIME_W)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_ptr       (rd_ptr),
    .wr_ptr       (wr_ptr),
    .count        (count),
    .push_fire    (push_acc),
    .push_cmd     (push_cmd),
    .push_order   (push_order),
    .push_time    (push_time),
    .push_src     (push_src),
    .push_mark    (push_mark),
    .merge_fire   (app_acc),
    .merge_cnt    (app_cnt),
    .merge_cmd    (app_cmd),
    .merge_order  (app_order),
    .merge_time   (app_time),
    .merge_src    (app_src),
    .merge_mark   (app_mark),
    .rewrite_fire (rewrite_acc),
    .head_cmd     (head_cmd),
    .head_order   (head_order),
    .head_time    (head_time),
    .head_src     (head_src),
    .head_mark    (head_mark)
  );

  ptq_flag_unit u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .rewrite_fire (rewrite_acc),
    .clear_fire   (clear_acc),
    .push_fire    (push_acc),
    .push_cmd     (push_cmd),
    .push_src     (push_src),
    .merge_fire   (app_acc),
    .merge_excl   (app_excl),
    .merge_upg    (app_upg),
    .flag_excl    (flag_excl),
    .flag_upg     (flag_upg)
  );

endmodule

// File: rtl/ptq_checker.sv
module ptq_checker
  import ptq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ORDER_W = 8,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_valid,
  input logic [3:0]         push_cmd,
  input logic [1:0]         push_src,
  input logic               pop,
  input logic               rewrite,
  input logic               flag_clear,
  input logic               app_valid,
  input logic [CNT_W-1:0]   count,
  input logic               head_valid,
  input logic [3:0]         head_cmd,
  input logic [ORDER_W-1:0] head_order,
  input logic               flag_excl,
  input logic               flag_upg,
  input logic               push_acc,
  input logic               pop_acc,
  input logic               app_acc
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (count == '0) && !head_valid && !flag_excl && !flag_upg);

  a_r2_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && !pop && !rewrite |=> $stable(head_cmd) && $stable(head_order));

  a_r3_excl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_excl && !(flag_clear && count == '0) |=> flag_excl);

  a_r4_upg_set: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && push_src != SRC_SNOOP && is_upgrade_kind(push_cmd) |=> flag_upg);

  a_r5_snoop_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_src == SRC_SNOOP && !rewrite && !app_valid
    |=> $stable(flag_excl) && $stable(flag_upg));

  a_r6_rewrite_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite && !push_valid && !app_acc |=> !flag_upg);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop && count == '0 && !push_valid && !app_acc |=> count == '0);

  a_r8_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc && !push_acc && !app_acc |=> count == $past(count) - CNT_W'(1));

endmodule

bind pending_target_queue ptq_checker #(.DEPTH(DEPTH), .ORDER_W(ORDER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_cmd   (push_cmd),
  .push_src   (push_src),
  .pop        (pop),
  .rewrite    (rewrite),
  .flag_clear (flag_clear),
  .app_valid  (app_valid),
  .count      (count),
  .head_valid (head_valid),
  .head_cmd   (head_cmd),
  .head_order (head_order),
  .flag_excl  (flag_excl),
  .flag_upg   (flag_upg),
  .push_acc   (push_acc),
  .pop_acc    (pop_acc),
  .app_acc    (app_acc)
);

// File: tb/pending_target_queue_tb.sv
`timescale 1ns/1ps
module pending_target_queue_tb;

  localparam int DEPTH = 8;
  localparam int OW    = 8;
  localparam int TW    = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            push_valid = 0;
  logic [3:0]      push_cmd = 0;
  logic [OW-1:0]   push_order = 0;
  logic [TW-1:0]   push_time = 0;
  logic [1:0]      push_src = 0;
  logic            push_mark = 0;
  logic            pop = 0, rewrite = 0, flag_clear = 0, app_valid = 0;
  logic [CW-1:0]   app_cnt = 0;
  logic [4*DEPTH-1:0]  app_cmd = 0;
  logic [OW*DEPTH-1:0] app_order = 0;
  logic [TW*DEPTH-1:0] app_time = 0;
  logic [2*DEPTH-1:0]  app_src = 0;
  logic [DEPTH-1:0]    app_mark = 0;
  logic            app_excl = 0, app_upg = 0;

  logic [CW-1:0] count;
  logic empty, full, head_valid, head_mark, flag_excl, flag_upg;
  logic [3:0] head_cmd;
  logic [OW-1:0] head_order;
  logic [TW-1:0] head_time;
  logic [1:0] head_src;

  pending_target_queue #(.DEPTH(DEPTH), .ORDER_W(OW), .TIME_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_cmd(push_cmd), .push_order(push_order),
    .push_time(push_time), .push_src(push_src), .push_mark(push_mark),
    .pop(pop), .rewrite(rewrite), .flag_clear(flag_clear),
    .app_valid(app_valid), .app_cnt(app_cnt), .app_cmd(app_cmd),
    .app_order(app_order), .app_time(app_time), .app_src(app_src),
    .app_mark(app_mark), .app_excl(app_excl), .app_upg(app_upg),
    .count(count), .empty(empty), .full(full), .head_valid(head_valid),
    .head_cmd(head_cmd), .head_order(head_order), .head_time(head_time),
    .head_src(head_src), .head_mark(head_mark),
    .flag_excl(flag_excl), .flag_upg(flag_upg)
  );

  int n_checks = 0;
  int n_fail = 0;

  // reference model
  logic [3:0]    q_cmd[$];
  logic [OW-1:0] q_ord[$];
  logic [TW-1:0] q_tim[$];
  logic [1:0]    q_src[$];
  logic          q_mrk[$];
  logic m_ex = 0, m_up = 0;

  function automatic logic ref_excl(input logic [3:0] c);
    case (c)
      4'd0, 4'd8: return 1'b0;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_upg(input logic [3:0] c);
    return c == 4'd2 || c == 4'd3 || c == 4'd4;
  endfunction

  function automatic logic [3:0] ref_fix(input logic [3:0] c);
    if (c == 4'd2) return 4'd1;
    if (c == 4'd3) return 4'd6;
    if (c == 4'd4) return 4'd7;
    return c;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count", 32'(count), 32'(q_cmd.size()));
    chk(tag, "empty", 32'(empty), 32'(q_cmd.size() == 0));
    chk(tag, "full", 32'(full), 32'(q_cmd.size() == DEPTH));
    chk(tag, "head_valid", 32'(head_valid), 32'(q_cmd.size() != 0));
    chk(tag, "flag_excl", 32'(flag_excl), 32'(m_ex));
    chk(tag, "flag_upg", 32'(flag_upg), 32'(m_up));
    if (q_cmd.size() != 0) begin
      chk(tag, "head_cmd", 32'(head_cmd), 32'(q_cmd[0]));
      chk(tag, "head_order", 32'(head_order), 32'(q_ord[0]));
      chk(tag, "head_time", 32'(head_time), 32'(q_tim[0]));
      chk(tag, "head_src", 32'(head_src), 32'(q_src[0]));
      chk(tag, "head_mark", 32'(head_mark), 32'(q_mrk[0]));
    end
  endtask

  task automatic model_step();
    int n = q_cmd.size();
    logic app_ok = app_valid && !push_valid && !pop && (n + int'(app_cnt) <= DEPTH);
    logic clr_ok = flag_clear && n == 0 && !push_valid && !app_valid;
    logic push_ok = push_valid && (n < DEPTH || pop);
    if (rewrite && m_up) begin
      foreach (q_cmd[i]) q_cmd[i] = ref_fix(q_cmd[i]);
      m_up = 0;
    end
    if (clr_ok) begin m_ex = 0; m_up = 0; end
    if (pop && n > 0) begin
      void'(q_cmd.pop_front()); void'(q_ord.pop_front());
      void'(q_tim.pop_front()); void'(q_src.pop_front());
      void'(q_mrk.pop_front());
    end
    if (push_ok) begin
      q_cmd.push_back(push_cmd); q_ord.push_back(push_order);
      q_tim.push_back(push_time); q_src.push_back(push_src);
      q_mrk.push_back(push_mark);
      if (push_src != 2'd1) begin
        m_ex = m_ex | ref_excl(push_cmd);
        m_up = m_up | ref_upg(push_cmd);
      end
    end
    if (app_ok) begin
      for (int k = 0; k < int'(app_cnt); k++) begin
        q_cmd.push_back(app_cmd[k*4 +: 4]);
        q_ord.push_back(app_order[k*OW +: OW]);
        q_tim.push_back(app_time[k*TW +: TW]);
        q_src.push_back(app_src[k*2 +: 2]);
        q_mrk.push_back(app_mark[k]);
      end
      m_ex = m_ex | app_excl;
      m_up = m_up | app_upg;
    end
  endtask

  task automatic idle();
    push_valid = 0; pop = 0; rewrite = 0; flag_clear = 0; app_valid = 0;
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
    compare_all(tag);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    q_cmd.delete(); q_ord.delete(); q_tim.delete(); q_src.delete(); q_mrk.delete();
    m_ex = 0; m_up = 0;
    compare_all("R1");
    rst_n = 1;
  endtask

  task automatic set_push(input logic [3:0] c, input logic [1:0] s);
    push_valid = 1; push_cmd = c; push_src = s;
    push_order = OW'($urandom); push_time = TW'($urandom); push_mark = 1'($urandom);
  endtask

  task automatic rand_app();
    app_cmd = '0;
    for (int k = 0; k < DEPTH; k++) begin
      app_cmd[k*4 +: 4] = 4'($urandom_range(8, 0));
      app_src[k*2 +: 2] = 2'($urandom_range(2, 0));
    end
    app_order = {DEPTH{OW'($urandom)}} ^ OW*DEPTH'($urandom);
    app_time = {($urandom), ($urandom), ($urandom), ($urandom)};
    app_mark = DEPTH'($urandom);
    app_excl = 1'($urandom); app_upg = 1'($urandom);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();

    // R3: read does not set exclusive, read-exclusive does
    set_push(4'd0, 2'd0); cycle("R3");
    set_push(4'd1, 2'd0); cycle("R3");
    chk("R3", "flag_excl literal", 32'(flag_excl), 32'd1);

    // R5 and R7: snoop-sourced upgrades leave flags alone, rewrite inert
    do_reset();
    set_push(4'd2, 2'd1); cycle("R5");
    set_push(4'd4, 2'd1); cycle("R5");
    chk("R5", "flag_upg literal", 32'(flag_upg), 32'd0);
    rewrite = 1; cycle("R7");
    chk("R7", "head_cmd literal", 32'(head_cmd), 32'd2);
    pop = 1; cycle("R7");
    chk("R7", "second cmd literal", 32'(head_cmd), 32'd4);

    // R9: clear ignored while non-empty or with push, taken when empty
    do_reset();
    set_push(4'd5, 2'd2); cycle("R3");
    flag_clear = 1; cycle("R9");
    chk("R9", "excl kept", 32'(flag_excl), 32'd1);
    pop = 1; cycle("R9");
    flag_clear = 1; set_push(4'd0, 2'd0); cycle("R9");
    pop = 1; cycle("R9");
    flag_clear = 1; cycle("R9");
    chk("R9", "excl cleared", 32'(flag_excl), 32'd0);

    // R4 and R6: upgrade kinds set flag, rewrite maps all in one cycle
    do_reset();
    set_push(4'd2, 2'd0); cycle("R4");
    set_push(4'd3, 2'd2); cycle("R4");
    set_push(4'd4, 2'd0); cycle("R4");
    set_push(4'd0, 2'd0); cycle("R4");
    chk("R4", "flag_upg literal", 32'(flag_upg), 32'd1);
    rewrite = 1; set_push(4'd2, 2'd1); cycle("R6");
    chk("R6", "flag_upg cleared", 32'(flag_upg), 32'd0);
    chk("R6", "upgrade->readex", 32'(head_cmd), 32'd1);
    pop = 1; cycle("R6");
    chk("R6", "scupg->scupgfail", 32'(head_cmd), 32'd6);
    pop = 1; cycle("R6");
    chk("R6", "sc->scfail", 32'(head_cmd), 32'd7);
    pop = 1; cycle("R6");
    pop = 1; cycle("R6");
    chk("R6", "same-cycle push kept", 32'(head_cmd), 32'd2);

    // R8: full, dropped push, push+pop when full, pop on empty
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin set_push(4'($urandom_range(8, 0)), 2'd0); cycle("R2"); end
    set_push(4'd0, 2'd0); cycle("R8");
    chk("R8", "count at full", 32'(count), 32'(DEPTH));
    set_push(4'd5, 2'd0); pop = 1; cycle("R8");
    for (int i = 0; i < DEPTH + 2; i++) begin pop = 1; cycle("R8"); end
    chk("R8", "empty after drain", 32'(empty), 32'd1);

    // R10: append behind entries, rejected on overflow or with push/pop
    do_reset();
    set_push(4'd0, 2'd0); cycle("R10");
    set_push(4'd8, 2'd2); cycle("R10");
    rand_app(); app_valid = 1; app_cnt = 3; cycle("R10");
    chk("R10", "count after append", 32'(count), 32'd5);
    rand_app(); app_valid = 1; app_cnt = 4; cycle("R10");
    chk("R10", "overflow rejected", 32'(count), 32'd5);
    rand_app(); app_valid = 1; app_cnt = 1; pop = 1; cycle("R10");
    for (int i = 0; i < 6; i++) begin pop = 1; cycle("R10"); end

    // R2: random mix against the model
    do_reset();
    for (int it = 0; it < 4000; it++) begin
      int r = $urandom_range(99, 0);
      if ($urandom_range(99, 0) < 55) set_push(4'($urandom_range(8, 0)), 2'($urandom_range(2, 0)));
      pop = ($urandom_range(99, 0) < 40);
      rewrite = (r < 12);
      flag_clear = ($urandom_range(99, 0) < 6);
      if ($urandom_range(99, 0) < 10) begin
        rand_app(); app_valid = 1; app_cnt = CW'($urandom_range(DEPTH, 0));
      end
      cycle("R2");
    end

    finish_run();
  end

endmodule